// File: doc/BRIEF.md
# Phase Generator for Direct Digital Synthesis

This block produces the phase word that drives a sine lookup in a direct digital synthesis chain. A wide phase accumulator adds a frequency tuning word on every clock. The top bits of the accumulator, plus a programmable phase offset, form the output phase word. The offset can be held fixed to align the output with another signal. It can also be rewritten repeatedly to apply phase modulation.

The host writes the tuning word, the offset and two clear controls into shadow registers. All of them move into the active set together on the clock edge where the update strobe is sampled.

Two clear controls force the accumulator to zero:
- **Hold clear** keeps the accumulator at zero for as long as it is active.
- **Auto clear** zeroes the accumulator once on each update strobe and then lets it run. It repeats on every later strobe until it is switched off.

Top module: `dds_phase_gen`

## Requirements
- R1: After reset, phaseWord is 0 and the active tuning word, offset, hold-clear bit and auto-clear bit are all zero.
- R2: On every clock edge without a clear, the 32-bit accumulator adds the active tuning word modulo 2^32. phaseWord is accumulator bits [31:18] plus the active offset.
- R3: Writes to the tuning word (tuneWrEn), the offset (offsetWrEn) or the controls (ctrlWrEn) change only shadow registers. Without an update strobe, they have no effect on phaseWord.
- R4: On the edge where updateStb is sampled high, every active register takes the shadow value it had before that edge. A new offset shows on phaseWord right after that edge. A new tuning word is first added on the following edge.
- R5: While the active hold-clear bit (ctrlData bit 0) is 1, the accumulator is zero after every edge. Once the bit becomes 0, accumulation restarts from zero.
- R6: When the auto-clear bit (ctrlData bit 1) being loaded by an update strobe is 1, that edge sets the accumulator to zero. The following edge adds the tuning word again.
- R7: Auto clear fires again on every later update strobe, until a control word with bit 1 equal to 0 has been loaded.
- R8: Hold clear takes priority over auto clear and over accumulation. With both bits set, the accumulator stays zero after the update edge.
- R9: The offset addition wraps modulo 2^14. It never changes the accumulator state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tuneWrEn | input | 1 | Write tuneData into the shadow tuning word |
| tuneData | input | 32 | Frequency tuning word |
| offsetWrEn | input | 1 | Write offsetData into the shadow offset |
| offsetData | input | 14 | Phase offset |
| ctrlWrEn | input | 1 | Write ctrlData into the shadow control bits |
| ctrlData | input | 2 | Bit 0 is hold clear, bit 1 is auto clear |
| updateStb | input | 1 | Copy all shadow registers into the active set |
| phaseWord | output | 14 | Output phase word |

## Verification
A corrupted accumulator shows on phaseWord in the first cycle in which its top 14 bits differ, so large tuning words expose it within one edge. A bad low bit shows once the carry reaches bit 18. A wrong active tuning word or offset shows one edge after the update strobe, as a wrong step or a wrong constant shift. A clear that fires or releases one cycle late shows as a single nonzero or zero sample next to the strobe or next to the clear edge.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef struct packed {
    logic holdZero;   // force accumulator to zero this edge
    logic clearOnce;  // one-shot zero from an update strobe
    logic loadActive; // shadow-to-active copy this edge
  } ctlStrobes_t;
endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl
  import dds_pkg::*;
#(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 14
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tuneWrEn,
  input  logic [FTW_W-1:0]   tuneData,
  input  logic               offsetWrEn,
  input  logic [PHASE_W-1:0] offsetData,
  input  logic               ctrlWrEn,
  input  logic [1:0]         ctrlData,
  input  logic               updateStb,
  output ctlStrobes_t        strobes,
  output logic [FTW_W-1:0]   activeTune,
  output logic [PHASE_W-1:0] activeOffset
);
  localparam int HOLD_BIT = 0;
  localparam int AUTO_BIT = 1;

  logic [FTW_W-1:0]   shTune;
  logic [PHASE_W-1:0] shOffset;
  logic [1:0]         shCtrl;
  logic [1:0]         actCtrl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shTune   <= '0;
      shOffset <= '0;
      shCtrl   <= '0;
    end else begin
      if (tuneWrEn)   shTune   <= tuneData;
      if (offsetWrEn) shOffset <= offsetData;
      if (ctrlWrEn)   shCtrl   <= ctrlData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeTune   <= '0;
      activeOffset <= '0;
      actCtrl      <= '0;
    end else if (updateStb) begin
      activeTune   <= shTune;
      activeOffset <= shOffset;
      actCtrl      <= shCtrl;
    end
  end

  always_comb begin
    strobes.loadActive = updateStb;
    strobes.holdZero   = updateStb ? shCtrl[HOLD_BIT] : actCtrl[HOLD_BIT];
    strobes.clearOnce  = updateStb & shCtrl[AUTO_BIT];
  end

  // R3
  tune_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updateStb |=> $stable(activeTune) && $stable(activeOffset));
  // R4
  tune_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    updateStb |=> activeTune == $past(shTune) && activeOffset == $past(shOffset));
endmodule

// File: rtl/dds_datapath.sv
module dds_datapath
  import dds_pkg::*;
#(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 14
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [FTW_W-1:0]   activeTune,
  input  logic [PHASE_W-1:0] activeOffset,
  output logic [PHASE_W-1:0] phaseWord
);
  localparam int TOP_LSB = FTW_W - PHASE_W;

  logic [FTW_W-1:0] acc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  acc <= '0;
    else if (strobes.holdZero)  acc <= '0;
    else if (strobes.clearOnce) acc <= '0;
    else                        acc <= acc + activeTune;
  end

  assign phaseWord = acc[FTW_W-1:TOP_LSB] + activeOffset;

  // R5 / R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdZero |=> acc == '0);
  // R6
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearOnce |=> acc == '0);
  // R2
  accum_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.holdZero && !strobes.clearOnce |=> acc == $past(acc) + $past(activeTune));
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
  import dds_pkg::*;
#(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 14
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tuneWrEn,
  input  logic [FTW_W-1:0]   tuneData,
  input  logic               offsetWrEn,
  input  logic [PHASE_W-1:0] offsetData,
  input  logic               ctrlWrEn,
  input  logic [1:0]         ctrlData,
  input  logic               updateStb,
  output logic [PHASE_W-1:0] phaseWord
);
  ctlStrobes_t        strobes;
  logic [FTW_W-1:0]   activeTune;
  logic [PHASE_W-1:0] activeOffset;

  dds_ctrl #(.FTW_W(FTW_W), .PHASE_W(PHASE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .tuneWrEn(tuneWrEn), .tuneData(tuneData),
    .offsetWrEn(offsetWrEn), .offsetData(offsetData),
    .ctrlWrEn(ctrlWrEn), .ctrlData(ctrlData),
    .updateStb(updateStb),
    .strobes(strobes), .activeTune(activeTune), .activeOffset(activeOffset)
  );

  dds_datapath #(.FTW_W(FTW_W), .PHASE_W(PHASE_W)) uPath (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .activeTune(activeTune), .activeOffset(activeOffset),
    .phaseWord(phaseWord)
  );
endmodule

// File: tb/sim_dds_phase_gen.sv
module sim_dds_phase_gen;
  logic        clk = 0;
  logic        rstN = 0;
  logic        tuneWrEn = 0;
  logic [31:0] tuneData = '0;
  logic        offsetWrEn = 0;
  logic [13:0] offsetData = '0;
  logic        ctrlWrEn = 0;
  logic [1:0]  ctrlData = '0;
  logic        updateStb = 0;
  logic [13:0] phaseWord;

  int checks = 0;
  int errors = 0;

  // reference state, built from the requirements
  logic [31:0] mAcc = '0, mTune = '0, sTune = '0;
  logic [13:0] mOff = '0, sOff = '0;
  logic [1:0]  mCtl = '0, sCtl = '0;

  always #2.5 clk = ~clk;

  dds_phase_gen u0 (
    .clk(clk), .rstN(rstN),
    .tuneWrEn(tuneWrEn), .tuneData(tuneData),
    .offsetWrEn(offsetWrEn), .offsetData(offsetData),
    .ctrlWrEn(ctrlWrEn), .ctrlData(ctrlData),
    .updateStb(updateStb), .phaseWord(phaseWord)
  );

  function automatic logic [13:0] expPhase(logic [31:0] a, logic [13:0] o);
    return a[31:18] + o;
  endfunction

  task automatic check(string req, logic [13:0] exp);
    checks++;
    if (phaseWord !== exp) begin
      errors++;
      $display("FAIL %s phaseWord=%h expected=%h", req, phaseWord, exp);
    end
  endtask

  // drive one cycle (called right after a falling edge), check after the next falling edge
  task automatic step(string req, bit wt, logic [31:0] td, bit wo, logic [13:0] od,
                      bit wc, logic [1:0] cd, bit up);
    logic hold;
    logic [31:0] nAcc;
    tuneWrEn = wt; tuneData = td; offsetWrEn = wo; offsetData = od;
    ctrlWrEn = wc; ctrlData = cd; updateStb = up;
    hold = up ? sCtl[0] : mCtl[0];
    if (hold)              nAcc = '0;   // R8 priority
    else if (up && sCtl[1]) nAcc = '0;   // R6
    else                   nAcc = mAcc + mTune;
    if (up) begin mTune = sTune; mOff = sOff; mCtl = sCtl; end
    if (wt) sTune = td;
    if (wo) sOff = od;
    if (wc) sCtl = cd;
    mAcc = nAcc;
    @(negedge clk);
    check(req, expPhase(mAcc, mOff));
  endtask

  task automatic idle(string req, int n);
    for (int i = 0; i < n; i++) step(req, 0, '0, 0, '0, 0, '0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", 14'h0);
    rstN = 1;
    @(negedge clk);
    check("R1", 14'h0);
    idle("R1", 3);
    // R3: shadow write alone must not move the output
    step("R3", 1, 32'h0100_0000, 1, 14'h0123, 0, '0, 0);
    idle("R3", 4);
    // R4: load, offset visible at once, tuning word from next edge
    step("R4", 0, '0, 0, '0, 0, '0, 1);
    idle("R2", 10);
    // R9: offset wraps
    step("R9", 0, '0, 1, 14'h3FFF, 0, '0, 0);
    step("R9", 0, '0, 0, '0, 0, '0, 1);
    idle("R9", 8);
    // R5: hold clear
    step("R5", 0, '0, 0, '0, 1, 2'b01, 1);
    step("R5", 0, '0, 0, '0, 1, 2'b00, 0);
    idle("R5", 5);
    step("R5", 0, '0, 0, '0, 0, '0, 1);
    idle("R5", 6);
    // R6/R7: auto clear on each strobe
    step("R6", 0, '0, 0, '0, 1, 2'b10, 1);
    step("R6", 0, '0, 0, '0, 0, '0, 1);
    idle("R6", 5);
    step("R7", 1, 32'h0ABC_0000, 0, '0, 0, '0, 1);
    idle("R7", 5);
    step("R7", 0, '0, 0, '0, 1, 2'b00, 1);
    step("R7", 0, '0, 0, '0, 0, '0, 1);
    idle("R7", 5);
    step("R7", 0, '0, 0, '0, 0, '0, 1);
    idle("R7", 3);
    // R8: both bits set, stays zero
    step("R8", 0, '0, 0, '0, 1, 2'b11, 1);
    step("R8", 0, '0, 0, '0, 0, '0, 1);
    idle("R8", 4);
    step("R8", 0, '0, 0, '0, 1, 2'b00, 1);
    step("R8", 0, '0, 0, '0, 0, '0, 1);
    idle("R8", 4);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit wt, wo, wc, up;
      wt = ($urandom % 8) == 0;
      wo = ($urandom % 6) == 0;
      wc = ($urandom % 20) == 0;
      up = ($urandom % 10) == 0;
      step("R2", wt, $urandom, wo, 14'($urandom), wc, 2'($urandom), up);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule